// File: doc/BRIEF.md
# Geometry Coprocessor Data Register File

This block holds the 32 data registers of a geometry coprocessor. Each register is 32 bits wide. There is one combinational read port and one synchronous write port. Most indices are plain storage. Some indices change what a read returns, and some have side effects when written.

On the read side, some halfword registers are returned sign-extended and others zero-extended. One alias index returns the newest entry of a three-deep screen-coordinate queue. Two indices return a 15-bit colour word, packed from three component registers with saturation.

On the write side, a push alias shifts the coordinate queue. A packed colour word is split into the three component registers. Writing the count source stores, alongside the value, the length of its run of leading sign bits, and the count register cannot be written directly. The rest of the coprocessor uses it as its data register bank.

Top module: `geo_dreg`

## Requirements
- R1: A read of index 1, 3, 5, 8, 9, 10 or 11 returns the low 16 bits of that register, sign-extended to 32 bits.
- R2: A read of index 7, 16, 17, 18 or 19 returns the low 16 bits of that register, zero-extended to 32 bits.
- R3: A read of index 15 returns the current content of register 14.
- R4: A write to index 15 moves, at one clock edge, the old value of register 13 into register 12 and the old value of register 14 into register 13, and places the written value in register 14.
- R5: A write to index 28 splits the written word into three 5-bit fields:
  - bits 4:0 go to register 9;
  - bits 9:5 go to register 10;
  - bits 14:10 go to register 11.

  Each field lands at bits 11:7 of its target, and all other bits of the target are zero.
- R6: A read of index 28 or 29 returns a packed colour. The result holds the fields from registers 9, 10 and 11 at bits 4:0, 9:5 and 14:10 respectively, with bits 31:15 zero. Each field is formed in three steps:
  - take the register's low 16 bits as a signed value;
  - shift it arithmetically right by 7;
  - clamp the result to the range 0 to 31.
- R7: A write to index 30 stores the value. It also sets register 31 to the number of leading bits that equal bit 31, which is 32 for an all-zero or all-one value.
- R8: A write to index 31 leaves register 31 unchanged.
- R9: Every other index stores and returns the full 32-bit word.
- R10: A synchronous reset clears all 32 registers to zero.
- R11: A read and a write to the same index in one cycle return the value from before the write, and the new value is visible after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_idx | input | 5 | Read index |
| rd_data | output | 32 | Formatted read data, combinational |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Write index |
| wr_data | input | 32 | Write data |

## Verification
The bench builds the block with its default values: a 32-bit word, a 5-bit index and 5-bit colour fields at a shift of 7. With these values every special index is in reach. This covers both extension classes and a full three-push queue sequence. It also covers colour fields that clamp at both the low end and the high end of their range. For the leading-bit count, the bench reaches the extremes of 1 and 32 as well as mid-range counts from both positive and negative sources.

// File: rtl/geo_dreg_pkg.sv
package geo_dreg_pkg;
    localparam int REG_AW = 5;
    typedef logic [REG_AW-1:0] ridx_t;

    localparam ridx_t IDX_Q0     = 5'd12;
    localparam ridx_t IDX_Q1     = 5'd13;
    localparam ridx_t IDX_Q2     = 5'd14;
    localparam ridx_t IDX_PUSH   = 5'd15;
    localparam ridx_t IDX_COL_R  = 5'd9;
    localparam ridx_t IDX_PACK_A = 5'd28;
    localparam ridx_t IDX_PACK_B = 5'd29;
    localparam ridx_t IDX_LZ_SRC = 5'd30;
    localparam ridx_t IDX_LZ_CNT = 5'd31;

    typedef enum logic [2:0] {RK_RAW, RK_SEXT, RK_ZEXT, RK_QTOP, RK_PACK} rd_kind_e;
    typedef enum logic [2:0] {WK_PLAIN, WK_PUSH, WK_UNPACK, WK_LZ, WK_DROP} wr_kind_e;

    function automatic rd_kind_e rd_kind(ridx_t idx);
        case (idx)
            5'd1, 5'd3, 5'd5, 5'd8, 5'd9, 5'd10, 5'd11: return RK_SEXT;
            5'd7, 5'd16, 5'd17, 5'd18, 5'd19:           return RK_ZEXT;
            IDX_PUSH:                                   return RK_QTOP;
            IDX_PACK_A, IDX_PACK_B:                     return RK_PACK;
            default:                                    return RK_RAW;
        endcase
    endfunction

    function automatic wr_kind_e wr_kind(ridx_t idx);
        case (idx)
            IDX_PUSH:   return WK_PUSH;
            IDX_PACK_A: return WK_UNPACK;
            IDX_LZ_SRC: return WK_LZ;
            IDX_LZ_CNT: return WK_DROP;
            default:    return WK_PLAIN;
        endcase
    endfunction
endpackage

// File: rtl/geo_dreg_lzc.sv
module geo_dreg_lzc #(
    parameter int W  = 32,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  val,
    output logic [CW-1:0] cnt
);
    logic [W-1:0] flip;

    always_comb begin
        // Leading sign bits become leading zeros after xor with the sign.
        flip = val ^ {W{val[W-1]}};
        cnt  = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (flip[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/geo_dreg_rdfmt.sv
module geo_dreg_rdfmt
    import geo_dreg_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = REG_AW,
    parameter int COL_W   = 5,
    parameter int COL_LSB = 7,
    localparam int NREG   = 2 ** AW,
    localparam int HW     = DW / 2,
    localparam int NCOL   = 3
) (
    input  logic [AW-1:0]           idx,
    input  logic [NREG-1:0][DW-1:0] rf,
    output logic [DW-1:0]           data
);
    logic [NCOL-1:0][COL_W-1:0] fld;

    // One saturating field extractor per colour component.
    for (genvar c = 0; c < NCOL; c++) begin : g_sat
        logic signed [HW-1:0] half;
        logic signed [HW-1:0] shr;
        assign half = rf[int'(IDX_COL_R) + c][HW-1:0];
        assign shr  = half >>> COL_LSB;
        always_comb begin
            if (shr[HW-1])                  fld[c] = '0;
            else if (|shr[HW-1:COL_W])      fld[c] = '1;
            else                            fld[c] = shr[COL_W-1:0];
        end
    end

    logic [DW-1:0] word;
    assign word = rf[idx];

    always_comb begin
        case (rd_kind(idx))
            RK_SEXT: data = {{(DW-HW){word[HW-1]}}, word[HW-1:0]};
            RK_ZEXT: data = {{(DW-HW){1'b0}}, word[HW-1:0]};
            RK_QTOP: data = rf[IDX_Q2];
            RK_PACK: data = {{(DW-NCOL*COL_W){1'b0}}, fld};
            default: data = word;
        endcase
    end
endmodule

// File: rtl/geo_dreg.sv
module geo_dreg
    import geo_dreg_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = REG_AW,
    parameter int COL_W   = 5,
    parameter int COL_LSB = 7,
    localparam int NREG   = 2 ** AW,
    localparam int CW     = $clog2(DW) + 1,
    localparam int NCOL   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] rf;
    } state_t;

    state_t st_d, st_q;
    logic [CW-1:0] lz_cnt;

    geo_dreg_lzc #(.W(DW), .CW(CW)) u_lzc (
        .val (wr_data),
        .cnt (lz_cnt)
    );

    geo_dreg_rdfmt #(.DW(DW), .AW(AW), .COL_W(COL_W), .COL_LSB(COL_LSB)) u_rdfmt (
        .idx  (rd_idx),
        .rf   (st_q.rf),
        .data (rd_data)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_kind(wr_idx))
                WK_PUSH: begin
                    st_d.rf[IDX_Q0]   = st_q.rf[IDX_Q1];
                    st_d.rf[IDX_Q1]   = st_q.rf[IDX_Q2];
                    st_d.rf[IDX_Q2]   = wr_data;
                    st_d.rf[IDX_PUSH] = wr_data;
                end
                WK_UNPACK: begin
                    st_d.rf[IDX_PACK_A] = wr_data;
                    for (int c = 0; c < NCOL; c++) begin
                        st_d.rf[int'(IDX_COL_R) + c] =
                            DW'(wr_data[c*COL_W +: COL_W]) << COL_LSB;
                    end
                end
                WK_LZ: begin
                    st_d.rf[IDX_LZ_SRC] = wr_data;
                    st_d.rf[IDX_LZ_CNT] = DW'(lz_cnt);
                end
                WK_DROP: ;
                default: st_d.rf[wr_idx] = wr_data;
            endcase
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    AST_RST_CLEAR: assert property (@(posedge clk) rst |=> st_q.rf == '0) else $error("reset"); // R10
    AST_SEXT_READ: assert property (@(posedge clk) disable iff (rst)
        rd_idx == 5'd3 |-> rd_data[DW-1:DW/2] == {(DW/2){rd_data[DW/2-1]}}) else $error("sext"); // R1
    AST_QTOP_READ: assert property (@(posedge clk) disable iff (rst)
        rd_idx == IDX_PUSH |-> rd_data == st_q.rf[IDX_Q2]) else $error("qtop"); // R3
    AST_QUEUE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_PUSH) |=>
            (st_q.rf[IDX_Q0] == $past(st_q.rf[IDX_Q1]) &&
             st_q.rf[IDX_Q1] == $past(st_q.rf[IDX_Q2]) &&
             st_q.rf[IDX_Q2] == $past(wr_data))) else $error("shift"); // R4
    AST_LZ_RANGE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_LZ_SRC) |=>
            (st_q.rf[IDX_LZ_CNT] <= DW && st_q.rf[IDX_LZ_CNT] >= 1)) else $error("lz"); // R7
    AST_CNT_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_LZ_CNT) |=> $stable(st_q.rf[IDX_LZ_CNT])) else $error("ro"); // R8
    AST_PACK_HIGH: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == IDX_PACK_A || rd_idx == IDX_PACK_B) |-> rd_data[DW-1:NCOL*COL_W] == '0) else $error("pack"); // R6
endmodule

// File: tb/geo_dreg_bench.sv
module geo_dreg_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd_idx;
    logic [31:0] rd_data;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    geo_dreg u_geo_dreg (
        .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            finish_run();
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] idx, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [4:0] idx, logic [31:0] exp);
        @(negedge clk);
        rd_idx = idx;
        #1 chk(req, rd_data, exp);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 32; i++) rd_chk("R10", 5'(i), 32'h0);
    endtask

    task automatic t_plain();
        wr(5'd0, 32'hDEADBEEF);  rd_chk("R9", 5'd0, 32'hDEADBEEF);
        wr(5'd2, 32'h8000_0001); rd_chk("R9", 5'd2, 32'h8000_0001);
        wr(5'd27, 32'hFFFF_8000); rd_chk("R9", 5'd27, 32'hFFFF_8000);
    endtask

    task automatic t_ext();
        wr(5'd1, 32'h1234_8001); rd_chk("R1", 5'd1, 32'hFFFF_8001);
        wr(5'd3, 32'hABCD_7FFF); rd_chk("R1", 5'd3, 32'h0000_7FFF);
        wr(5'd8, 32'h0000_FFFF); rd_chk("R1", 5'd8, 32'hFFFF_FFFF);
        wr(5'd7, 32'hFFFF_8001); rd_chk("R2", 5'd7, 32'h0000_8001);
        wr(5'd19, 32'h8765_FFFE); rd_chk("R2", 5'd19, 32'h0000_FFFE);
    endtask

    task automatic t_queue();
        wr(5'd15, 32'h0011_0022);
        rd_chk("R4", 5'd14, 32'h0011_0022);
        rd_chk("R4", 5'd13, 32'h0);
        wr(5'd15, 32'h0033_0044);
        wr(5'd15, 32'h0055_0066);
        rd_chk("R4", 5'd12, 32'h0011_0022);
        rd_chk("R4", 5'd13, 32'h0033_0044);
        rd_chk("R4", 5'd14, 32'h0055_0066);
        rd_chk("R3", 5'd15, 32'h0055_0066);
        wr(5'd14, 32'hCAFE_F00D);
        rd_chk("R3", 5'd15, 32'hCAFE_F00D);
    endtask

    task automatic t_colour();
        // fields 3, 13, 1 -> targets 3<<7, 13<<7, 1<<7
        wr(5'd28, 32'hFFFF_05A3);
        rd_chk("R5", 5'd9,  32'h0000_0180);
        rd_chk("R5", 5'd10, 32'h0000_0680);
        rd_chk("R5", 5'd11, 32'h0000_0080);
        rd_chk("R6", 5'd28, 32'h0000_05A3);
        rd_chk("R6", 5'd29, 32'h0000_05A3);
        // 0x1000>>7=32 clamps to 31; negative clamps to 0; 0x380>>7=7
        wr(5'd9,  32'h0000_1000);
        wr(5'd10, 32'hFFFF_FF00);
        wr(5'd11, 32'h0000_0380);
        rd_chk("R6", 5'd28, 32'h0000_1C1F);
    endtask

    task automatic t_lz();
        wr(5'd30, 32'h0000_0001); rd_chk("R7", 5'd31, 32'd31);
        rd_chk("R7", 5'd30, 32'h0000_0001);
        wr(5'd30, 32'hFFFF_0000); rd_chk("R7", 5'd31, 32'd16);
        wr(5'd30, 32'h0);         rd_chk("R7", 5'd31, 32'd32);
        wr(5'd30, 32'hFFFF_FFFF); rd_chk("R7", 5'd31, 32'd32);
        wr(5'd30, 32'h4000_0000); rd_chk("R7", 5'd31, 32'd1);
        wr(5'd30, 32'h8000_0000); rd_chk("R7", 5'd31, 32'd1);
    endtask

    task automatic t_ro();
        wr(5'd30, 32'h0000_0100);
        wr(5'd31, 32'h5555_5555);
        rd_chk("R8", 5'd31, 32'd23);
    endtask

    task automatic t_rw_same();
        wr(5'd4, 32'h1111_1111);
        @(negedge clk);
        rd_idx = 5'd4; wr_en = 1'b1; wr_idx = 5'd4; wr_data = 32'h2222_2222;
        #1 chk("R11", rd_data, 32'h1111_1111);
        @(negedge clk);
        wr_en = 1'b0;
        #1 chk("R11", rd_data, 32'h2222_2222);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain();
        t_ext();
        t_queue();
        t_colour();
        t_lz();
        t_ro();
        t_rw_same();
        wr(5'd0, 32'h7);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_chk("R10", 5'd0, 32'h0);
        rd_chk("R10", 5'd14, 32'h0);
        finish_run();
    end
endmodule